// File: doc/BRIEF.md
# Non-PCM Burst Preamble Detector

This block sits behind a digital audio receiver that has already recovered 16-bit sub-frame data words. It watches that word stream for the six-word sync pattern that marks the start of a compressed-audio burst. When the full pattern is seen, it raises a non-PCM flag so that downstream logic can stop treating the samples as linear PCM.

The two burst-information words that follow each sync pattern carry the burst type and the burst length. They are captured automatically into two held registers. The flag is not a one-shot. It stays raised for a fixed number of frames after the most recent sync. It drops only when that many frame-start strobes have passed with no new sync, so a steady compressed stream keeps the flag high without gaps.

The design has three parts. A position matcher follows the pattern. A two-step capture unit loads the burst-information words. A frame counter sets the timeout for the flag.

Top module: `nonpcm_burst_detect`

## Requirements
- R1: A synchronous active-low reset (rst_n low at a clock edge) clears nonpcm_o, burst_pc_o, burst_pd_o and the frame count to zero.
- R2: When six valid words arrive in order as 0x0000, 0x0000, 0x0000, 0x0000, 0xF872, 0x4E1F, nonpcm_o is high from the clock edge that accepts the 0x4E1F word.
- R3: Once the flag is set, it stays high until 4096 frame_start_i strobes have been accepted since the last match. It goes low at the edge that accepts the 4096th strobe.
- R4: Each new match restarts the 4096-frame count. When a match and a frame strobe fall in the same cycle, that strobe is not counted.
- R5: A valid word that breaks the sequence restarts the matcher. If that word is 0x0000, it counts as the first word of a new attempt. As a result, N zeros followed by 0xF872, 0x4E1F match exactly when N is a nonzero multiple of 4.
- R6: A word presented with word_vld_i low is ignored by both the matcher and the capture unit.
- R7: After a match, the first valid word loads burst_pc_o and the second valid word loads burst_pd_o. Each register updates at the clock edge that accepts its word.
- R8: burst_pc_o and burst_pd_o hold their values across incomplete or broken sequences and across any later words. They change only in the two word slots that follow a complete match.
- R9: While the flag is low, frame strobes alone never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_i | input | 16 | Sub-frame data word |
| word_vld_i | input | 1 | word_i carries a word this cycle |
| frame_start_i | input | 1 | One-cycle strobe at each frame start |
| nonpcm_o | output | 1 | Compressed-stream flag |
| burst_pc_o | output | 16 | First burst-information word after the last sync |
| burst_pd_o | output | 16 | Second burst-information word after the last sync |

## Verification
The matcher is swept with every single-bit corruption of every pattern position. This shows that each of the 96 compared bits matters. It is also swept with runs of 1 to 12 zeros ahead of the 0xF872/0x4E1F tail, which tells the zero-restart rule apart from a matcher that slides back over the zeros. Invalid garbage is interleaved inside the pattern and inside the capture slots to show that the valid gating holds. The frame timeout is stepped strobe by strobe up to its limit, after a plain match, after a mid-window re-sync, and after a sync that lands on a frame strobe. This separates an off-by-one limit, a missing restart and a miscounted coincident strobe.

// File: rtl/nonpcm_pkg.sv
// Package: shared constants, the sync pattern lookup and the capture phase type.
// Assumes 16-bit sub-frame words; the pattern values are fixed by the stream format.
package nonpcm_pkg;

    localparam int WORD_W   = 16;
    localparam int SYNC_LEN = 6;

    // Expected word at each position of the burst sync pattern.
    function automatic logic [WORD_W-1:0] sync_word(input int unsigned pos);
        case (pos)
            4:       sync_word = 16'hF872;
            5:       sync_word = 16'h4E1F;
            default: sync_word = 16'h0000;
        endcase
    endfunction

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_PC   = 2'd1,
        CAP_PD   = 2'd2
    } cap_phase_t;

endpackage

// File: rtl/nonpcm_sync_matcher.sv
// Module: tracks the position reached in the sync pattern, one valid word at a time.
// Pulses sync_hit_o in the cycle the final pattern word is presented.
// Assumes a mismatching word restarts the search, and that a mismatching word
// equal to the first pattern word counts as position one of a new attempt.
module nonpcm_sync_matcher
    import nonpcm_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int LEN = SYNC_LEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_i,
    input  logic         vld_i,
    output logic         sync_hit_o
);
    localparam int IDX_W = $clog2(LEN + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LEN - 1);

    logic [IDX_W-1:0] idx;
    logic [LEN-1:0]   pos_eq;
    logic             expect_ok;
    logic             at_last;

    // One comparator per pattern position.
    for (genvar g = 0; g < LEN; g++) begin : g_cmp
        assign pos_eq[g] = (word_i == W'(sync_word(g)));
    end

    // Compare against the word expected at the current position.
    always_comb begin
        expect_ok = 1'b0;
        for (int k = 0; k < LEN; k++) begin
            if (idx == IDX_W'(k)) expect_ok = pos_eq[k];
        end
        at_last    = (idx == LAST_IDX);
        sync_hit_o = vld_i && expect_ok && at_last;
    end

    // Advance on a match, wrap after the last word, restart on a mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (vld_i) begin
            if (expect_ok) begin
                idx <= at_last ? '0 : idx + 1'b1;
            end else begin
                idx <= pos_eq[0] ? IDX_W'(1) : '0;
            end
        end
    end

    a_r5_zero_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !expect_ok && word_i == '0) |=> (idx == IDX_W'(1)));
    a_r6_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(idx));
    a_r2_hit_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit_o |=> (idx == '0));
    a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX);

endmodule

// File: rtl/nonpcm_burst_capture.sv
// Module: after each sync hit, loads the next two valid words into the Pc and Pd registers.
// Assumes sync_hit_o marks the final pattern word, which itself is not captured.
// A new sync hit during capture restarts the sequence at Pc.
module nonpcm_burst_capture
    import nonpcm_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_hit_i,
    input  logic [W-1:0] word_i,
    input  logic         vld_i,
    output logic [W-1:0] pc_o,
    output logic [W-1:0] pd_o
);
    cap_phase_t phase;

    // Step through the two capture slots after a sync hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= CAP_IDLE;
            pc_o  <= '0;
            pd_o  <= '0;
        end else if (sync_hit_i) begin
            phase <= CAP_PC;
        end else if (vld_i) begin
            case (phase)
                CAP_PC: begin
                    pc_o  <= word_i;
                    phase <= CAP_PD;
                end
                CAP_PD: begin
                    pd_o  <= word_i;
                    phase <= CAP_IDLE;
                end
                default: phase <= CAP_IDLE;
            endcase
        end
    end

    a_r8_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld_i && !sync_hit_i && phase == CAP_PC) |=> $stable(pc_o));
    a_r8_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld_i && !sync_hit_i && phase == CAP_PD) |=> $stable(pd_o));
    a_r7_pd_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !sync_hit_i && phase == CAP_PD) |=> (pd_o == $past(word_i)));
    a_r7_hit_arms: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit_i |=> (phase == CAP_PC));

endmodule

// File: rtl/nonpcm_frame_timeout.sv
// Module: holds the non-PCM flag for TIMEOUT frame strobes after the latest sync hit.
// Assumes frame_start_i is a one-cycle strobe. A sync hit takes priority over a
// coincident strobe, and that strobe is not counted.
module nonpcm_frame_timeout #(
    parameter int TIMEOUT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_hit_i,
    input  logic frame_start_i,
    output logic flag_o
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] cnt;

    // Set and restart on a sync hit, count frames while set, clear at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            cnt    <= '0;
        end else if (sync_hit_i) begin
            flag_o <= 1'b1;
            cnt    <= '0;
        end else if (flag_o && frame_start_i) begin
            if (cnt == CNT_LAST) begin
                flag_o <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r4_sync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit_i |=> (flag_o && cnt == '0));
    a_r3_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !frame_start_i) |=> flag_o);
    a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !sync_hit_i) |=> !flag_o);
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);

endmodule

// File: rtl/nonpcm_burst_detect.sv
// Module: top level of the compressed-stream detector. It joins the pattern matcher,
// the burst-information capture unit and the frame-count timeout.
// Assumes the words are already decoded sub-frame data, qualified by word_vld_i.
module nonpcm_burst_detect
    import nonpcm_pkg::*;
#(
    parameter int TIMEOUT_FRAMES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              word_vld_i,
    input  logic              frame_start_i,
    output logic              nonpcm_o,
    output logic [WORD_W-1:0] burst_pc_o,
    output logic [WORD_W-1:0] burst_pd_o
);
    logic sync_hit;

    // Pattern position tracking.
    nonpcm_sync_matcher #(.W(WORD_W), .LEN(SYNC_LEN)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_i     (word_i),
        .vld_i      (word_vld_i),
        .sync_hit_o (sync_hit)
    );

    // Capture of the two burst-information words.
    nonpcm_burst_capture #(.W(WORD_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_hit_i (sync_hit),
        .word_i     (word_i),
        .vld_i      (word_vld_i),
        .pc_o       (burst_pc_o),
        .pd_o       (burst_pd_o)
    );

    // Flag hold window counted in frames.
    nonpcm_frame_timeout #(.TIMEOUT(TIMEOUT_FRAMES)) u_tmo (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_hit_i    (sync_hit),
        .frame_start_i (frame_start_i),
        .flag_o        (nonpcm_o)
    );

    a_r2_flag_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |=> nonpcm_o);

endmodule

// File: tb/nonpcm_burst_detect_test.sv
// Bench: directed sweeps of the pattern, the zero-restart rule, the capture slots and the timeout.
module nonpcm_burst_detect_test;

    localparam int TMO = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] word = 16'h0;
    logic        vld = 1'b0;
    logic        fs = 1'b0;
    logic        flag;
    logic [15:0] pc, pd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    nonpcm_burst_detect #(.TIMEOUT_FRAMES(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .word_i(word), .word_vld_i(vld),
        .frame_start_i(fs), .nonpcm_o(flag), .burst_pc_o(pc), .burst_pd_o(pd)
    );

    function automatic logic [15:0] pat(input int i);
        return (i == 4) ? 16'hF872 : (i == 5) ? 16'h4E1F : 16'h0000;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; vld = 1'b0; fs = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    // One valid word, optionally with a frame strobe in the same cycle.
    task automatic put(input logic [15:0] w, input logic with_fs = 1'b0);
        @(negedge clk); word = w; vld = 1'b1; fs = with_fs;
        @(negedge clk); vld = 1'b0; fs = 1'b0; word = 16'hDEAD;
    endtask

    task automatic garbage();
        @(negedge clk); word = 16'hF872; vld = 1'b0;
        @(negedge clk); word = 16'h1234;
    endtask

    task automatic frame_tick();
        @(negedge clk); fs = 1'b1;
        @(negedge clk); fs = 1'b0;
    endtask

    task automatic send_sync();
        for (int i = 0; i < 6; i++) put(pat(i));
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 flag", {15'h0, flag}, 16'h0);
        chk("R1 pc", pc, 16'h0);
        chk("R1 pd", pd, 16'h0);

        // R9: frame strobes alone keep the flag low
        for (int i = 0; i < 5; i++) frame_tick();
        chk("R9 idle", {15'h0, flag}, 16'h0);

        // R2 / R7: plain match and capture
        for (int i = 0; i < 5; i++) put(pat(i));
        chk("R2 before last", {15'h0, flag}, 16'h0);
        put(pat(5));
        chk("R2 flag", {15'h0, flag}, 16'h1);
        put(16'h0015);
        chk("R7 pc", pc, 16'h0015);
        chk("R7 pd not yet", pd, 16'h0);
        put(16'h1800);
        chk("R7 pd", pd, 16'h1800);
        // R8: later words leave the registers alone
        put(16'hAAAA); put(16'h5555);
        chk("R8 pc hold", pc, 16'h0015);
        chk("R8 pd hold", pd, 16'h1800);

        // R1: reset mid-operation
        do_reset();
        chk("R1 flag again", {15'h0, flag}, 16'h0);
        chk("R1 pc again", pc, 16'h0);

        // R2 / R8: single-bit corruption of each position never matches
        for (int k = 0; k < 6; k++) begin
            for (int b = 0; b < 16; b++) begin
                do_reset();
                for (int i = 0; i < 6; i++)
                    put((i == k) ? (pat(i) ^ (16'h1 << b)) : pat(i));
                put(16'h7777); put(16'h8888);
                chk($sformatf("R2 corrupt k%0d b%0d flag", k, b), {15'h0, flag}, 16'h0);
                chk("R8 corrupt pc", pc, 16'h0);
                chk("R8 corrupt pd", pd, 16'h0);
            end
        end

        // R5: zero runs of length 1..12 before the tail
        for (int z = 1; z <= 12; z++) begin
            do_reset();
            put(16'h0101);
            for (int i = 0; i < z; i++) put(16'h0000);
            put(16'hF872); put(16'h4E1F);
            chk($sformatf("R5 zeros %0d", z), {15'h0, flag},
                {15'h0, (z % 4 == 0)});
        end
        // R5: nonzero mismatch inside the zeros, then four zeros
        do_reset();
        put(16'h0); put(16'h0); put(16'h0005);
        send_sync();
        chk("R5 nonzero restart", {15'h0, flag}, 16'h1);
        // R5: zero arriving in place of 0x4E1F restarts at position one
        do_reset();
        for (int i = 0; i < 5; i++) put(pat(i));
        put(16'h0); put(16'h0); put(16'h0); put(16'h0);
        put(16'hF872); put(16'h4E1F);
        chk("R5 zero at tail", {15'h0, flag}, 16'h1);

        // R6: invalid words interleaved with the pattern and the capture slots
        do_reset();
        for (int i = 0; i < 6; i++) begin
            garbage();
            put(pat(i));
        end
        chk("R6 match through gaps", {15'h0, flag}, 16'h1);
        garbage(); put(16'h0A0A); garbage(); put(16'h0B0B);
        chk("R6 pc", pc, 16'h0A0A);
        chk("R6 pd", pd, 16'h0B0B);

        // R3: strobe-by-strobe timeout
        do_reset();
        send_sync();
        for (int n = 1; n <= TMO; n++) begin
            frame_tick();
            chk($sformatf("R3 frame %0d", n), {15'h0, flag}, {15'h0, (n < TMO)});
        end

        // R4: re-sync mid-window restarts the count
        do_reset();
        send_sync();
        for (int n = 0; n < 2000; n++) frame_tick();
        send_sync();
        for (int n = 0; n < TMO - 1; n++) frame_tick();
        chk("R4 restart still high", {15'h0, flag}, 16'h1);
        frame_tick();
        chk("R4 restart expired", {15'h0, flag}, 16'h0);

        // R4: sync coinciding with a strobe, that strobe is not counted
        do_reset();
        send_sync();
        for (int n = 0; n < 100; n++) frame_tick();
        for (int i = 0; i < 5; i++) put(pat(i));
        put(pat(5), 1'b1);
        for (int n = 0; n < TMO - 1; n++) frame_tick();
        chk("R4 coincident still high", {15'h0, flag}, 16'h1);
        frame_tick();
        chk("R4 coincident expired", {15'h0, flag}, 16'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule